// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control word and the slot status word of a downstream port that supports hot-plug. Software reaches both words through one write port with byte enables and one combinational read port. The block also takes a hot or cold insertion request, a removal request and an attention-button press. Each write to the control word is treated as one command that completes at once. The block latches hot-plug events into write-one-to-clear status bits. It toggles an electromechanical interlock, and it refuses insertion and removal while that interlock is engaged.

Occupancy and interlock are tracked by a four-state machine: `ST_EMPTY`, `ST_FILLED`, `ST_EMPTY_LOCKED` and `ST_FILLED_LOCKED`.
- An accepted insertion moves an empty state to its filled twin.
- An accepted removal moves a filled state to its empty twin.
- An interlock toggle moves any state to its locked or unlocked twin.
- In the two locked states, a hot insertion or a removal leaves the state where it is and produces a busy response. A cold insertion is still accepted.

A second machine, with states `NF_QUIET` and `NF_RAISED`, follows the interrupt-pending level. It issues a message request on the `NF_QUIET`→`NF_RAISED` transition when a message mode is enabled. When neither message mode is enabled, it drives a level interrupt instead.

Top module: `hp_slot_ctrl`

Bit layout. Control word:

| Bits | Function |
|------|----------|
| 0 | attention-button enable |
| 3 | presence-change enable |
| 4 | command-done enable |
| 5 | hot-plug interrupt enable |
| 7:6 | attention indicator |
| 9:8 | power indicator |
| 11 | interlock control |

Status word:

| Bits | Function |
|------|----------|
| 0 | attention-button pressed |
| 3 | presence changed |
| 4 | command done |
| 6 | presence state |
| 7 | interlock engaged |

The indicator "off" encoding is 2'b11. `wr_sel`/`rd_sel` = 0 selects the control word and 1 selects the status word. `wr_be[0]` covers bits 7:0 and `wr_be[1]` covers bits 15:8.

## Requirements
- R1: After reset the control word reads 16'h03C0, the status word reads 16'h0000, and `hp_busy`, `msg_req` and `intx` are low.
- R2: Control bits 0, 3, 4, 5, 7:6 and 9:8 are read/write, each byte only when its `wr_be` bit is set. Every other control bit reads 0, including bit 11.
- R3: A control write with any `wr_be` bit set counts as one command and sets status bit 4, visible after that clock edge. A control write with `wr_be` = 0 changes nothing.
- R4: A status write clears each of bits 0, 3 and 4 where the data bit is 1 and `wr_be[0]` is set. Bits 6 and 7 are not affected. An event arriving in the same cycle as its clear leaves the bit set.
- R5: A control write with `wr_be[1]` set and data bit 11 = 1 inverts status bit 7.
- R6: An accepted hot insertion sets status bit 6. An accepted removal clears it. Both set status bit 3. When insertion and removal arrive together, the insertion wins.
- R7: A cold insertion (`ins_req` with `cold_flag`) sets status bit 6 without setting bit 3, and is accepted even while the interlock is engaged.
- R8: While status bit 7 is set, a hot insertion or a removal leaves bits 3 and 6 unchanged and raises `hp_busy` for exactly one cycle, after the clock edge that sampled the request.
- R9: `btn_press` sets status bit 0.
- R10: The pending level is control bit 5 AND a nonzero (status AND control) over bits 0, 3 and 4. With `msix_en` and `msi_en` both low, `intx` equals that level, one cycle later.
- R11: When the pending level goes from 0 to 1 while `msix_en` or `msi_en` is high, `msg_req` pulses for one cycle, one cycle later. At the same time `msg_vec` = `irq_vec` and `msg_msix` = `msix_en`. MSI-X takes precedence over MSI. An event on an already-set bit, or an event while the level is already high, issues no message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 1 | write target: 0 control, 1 status |
| wr_be | input | 2 | byte enables |
| wr_data | input | 16 | write data |
| rd_sel | input | 1 | read target: 0 control, 1 status |
| rd_data | output | 16 | read data |
| ins_req | input | 1 | insertion request |
| rem_req | input | 1 | removal request |
| cold_flag | input | 1 | qualifies `ins_req` as a cold insertion |
| btn_press | input | 1 | attention-button press |
| msix_en | input | 1 | MSI-X mode enabled |
| msi_en | input | 1 | MSI mode enabled |
| irq_vec | input | 5 | interrupt message number |
| hp_busy | output | 1 | request refused, interlock engaged |
| msg_req | output | 1 | one-cycle message request |
| msg_msix | output | 1 | kind of the last message: 1 MSI-X, 0 MSI |
| msg_vec | output | 5 | message number of the last message |
| intx | output | 1 | level interrupt |

## Verification
Two functions can collide in one cycle: the write-one-to-clear of a status event bit, and the setting of that same bit by a new event. The bench provokes this by holding `btn_press` or `rem_req` high during a status write that clears the matching bit. Reading the word back must show the bit still set. When the pending level was already high before the collision, `msg_req` must stay low.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int REG_W  = 16;
    localparam int BYTES  = REG_W / 8;

    // event bits share a position in both words; the pending level ANDs them
    localparam int B_ABP  = 0;
    localparam int B_PDC  = 3;
    localparam int B_CC   = 4;
    localparam int B_HPIE = 5;
    localparam int B_AIND = 6;
    localparam int B_PIND = 8;
    localparam int B_ILK  = 11;
    localparam int B_PDS  = 6;
    localparam int B_LOCK = 7;

    localparam logic [1:0] IND_OFF = 2'b11;

    localparam logic [REG_W-1:0] EVT_MASK =
        (REG_W'(1) << B_ABP) | (REG_W'(1) << B_PDC) | (REG_W'(1) << B_CC);
    localparam logic [REG_W-1:0] CTRL_RW =
        EVT_MASK | (REG_W'(1) << B_HPIE) |
        (REG_W'(3) << B_AIND) | (REG_W'(3) << B_PIND);
    localparam logic [REG_W-1:0] CTRL_RST =
        (REG_W'(IND_OFF) << B_AIND) | (REG_W'(IND_OFF) << B_PIND);

    typedef enum logic [1:0] {
        ST_EMPTY         = 2'b00,
        ST_FILLED        = 2'b01,
        ST_EMPTY_LOCKED  = 2'b10,
        ST_FILLED_LOCKED = 2'b11
    } slot_st_e;

    typedef enum logic {
        NF_QUIET  = 1'b0,
        NF_RAISED = 1'b1
    } nf_st_e;
endpackage

// File: rtl/hp_slot_fsm.sv
module hp_slot_fsm
    import hp_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins_req,
    input  logic rem_req,
    input  logic cold_flag,
    input  logic lock_toggle,
    output logic present,
    output logic locked,
    output logic pdc_evt,
    output logic busy
);
    slot_st_e state_q, state_d;
    logic hot_ins, cold_ins, rem_only;
    logic pres_n, lock_n, refuse;

    assign hot_ins  = ins_req & ~cold_flag;
    assign cold_ins = ins_req & cold_flag;
    assign rem_only = rem_req & ~ins_req;   // insertion wins a tie

    always_comb begin
        pres_n  = 1'b0;
        lock_n  = 1'b0;
        refuse  = 1'b0;
        pdc_evt = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                pres_n  = ins_req;
                lock_n  = lock_toggle;
                pdc_evt = hot_ins | rem_only;
            end
            ST_FILLED: begin
                pres_n  = ~rem_only;
                lock_n  = lock_toggle;
                pdc_evt = hot_ins | rem_only;
            end
            ST_EMPTY_LOCKED: begin
                pres_n  = cold_ins;
                lock_n  = ~lock_toggle;
                refuse  = hot_ins | rem_only;
            end
            ST_FILLED_LOCKED: begin
                pres_n  = 1'b1;
                lock_n  = ~lock_toggle;
                refuse  = hot_ins | rem_only;
            end
        endcase
        state_d = slot_st_e'({lock_n, pres_n});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= refuse;
    end

    always_comb begin
        present = (state_q == ST_FILLED) || (state_q == ST_FILLED_LOCKED);
        locked  = (state_q == ST_EMPTY_LOCKED) || (state_q == ST_FILLED_LOCKED);
    end

    p_toggle_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_toggle |=> (locked != $past(locked)));
    p_busy_holds_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(present));
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BYTES-1:0] wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             btn_press,
    input  logic             pdc_evt,
    input  logic             present,
    input  logic             locked,
    output logic [REG_W-1:0] ctrl_word,
    output logic [REG_W-1:0] stat_word,
    output logic             lock_toggle
);
    logic [REG_W-1:0] be_bits, ctrl_q, evt_q, evt_set, evt_clr;
    logic cmd, stat_wr;

    for (genvar gb = 0; gb < BYTES; gb++) begin : g_be
        assign be_bits[gb*8 +: 8] = {8{wr_be[gb]}};
    end

    assign cmd         = wr_en & ~wr_sel & (|wr_be);
    assign stat_wr     = wr_en & wr_sel;
    assign lock_toggle = cmd & be_bits[B_ILK] & wr_data[B_ILK];

    always_comb begin
        evt_set         = '0;
        evt_set[B_CC]   = cmd;
        evt_set[B_PDC]  = pdc_evt;
        evt_set[B_ABP]  = btn_press;
        evt_clr = stat_wr ? (wr_data & be_bits & EVT_MASK) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ctrl_q <= CTRL_RST;
        else if (cmd) ctrl_q <= (ctrl_q & ~(be_bits & CTRL_RW)) |
                                (wr_data & be_bits & CTRL_RW);
    end

    // a new event outranks a clear landing in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~evt_clr) | evt_set;
    end

    assign ctrl_word = ctrl_q;
    assign stat_word = evt_q | (REG_W'(present) << B_PDS) |
                       (REG_W'(locked) << B_LOCK);

    p_cmd_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd |=> stat_word[B_CC]);
    p_pdc_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pdc_evt |=> stat_word[B_PDC]);
    p_btn_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        btn_press |=> stat_word[B_ABP]);
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hpie,
    input  logic [REG_W-1:0] evt_en,
    input  logic [REG_W-1:0] evt_stat,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] irq_vec,
    output logic             msg_req,
    output logic             msg_msix,
    output logic [VEC_W-1:0] msg_vec,
    output logic             intx
);
    nf_st_e nf_q, nf_d;
    logic   pend, msg_mode, rise;

    assign pend     = hpie & (|(evt_stat & evt_en));
    assign msg_mode = msix_en | msi_en;
    assign nf_d     = pend ? NF_RAISED : NF_QUIET;

    always_comb begin
        rise = 1'b0;
        unique case (nf_q)
            NF_QUIET:  rise = (nf_d == NF_RAISED);
            NF_RAISED: rise = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nf_q <= NF_QUIET;
        else        nf_q <= nf_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_req  <= 1'b0;
            msg_msix <= 1'b0;
            msg_vec  <= '0;
            intx     <= 1'b0;
        end else begin
            msg_req <= rise & msg_mode;
            intx    <= pend & ~msg_mode;
            if (rise & msg_mode) begin
                msg_msix <= msix_en;
                msg_vec  <= irq_vec;
            end
        end
    end

    p_msg_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |=> !msg_req);
    p_intx_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_mode && $past(!msg_mode)) |-> (intx == $past(pend)));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BYTES-1:0] wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             ins_req,
    input  logic             rem_req,
    input  logic             cold_flag,
    input  logic             btn_press,
    input  logic             msix_en,
    input  logic             msi_en,
    input  logic [VEC_W-1:0] irq_vec,
    output logic             hp_busy,
    output logic             msg_req,
    output logic             msg_msix,
    output logic [VEC_W-1:0] msg_vec,
    output logic             intx
);
    logic [REG_W-1:0] ctrl_word, stat_word;
    logic present, locked, pdc_evt, lock_toggle;

    hp_slot_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ins_req     (ins_req),
        .rem_req     (rem_req),
        .cold_flag   (cold_flag),
        .lock_toggle (lock_toggle),
        .present     (present),
        .locked      (locked),
        .pdc_evt     (pdc_evt),
        .busy        (hp_busy)
    );

    hp_slot_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_be       (wr_be),
        .wr_data     (wr_data),
        .btn_press   (btn_press),
        .pdc_evt     (pdc_evt),
        .present     (present),
        .locked      (locked),
        .ctrl_word   (ctrl_word),
        .stat_word   (stat_word),
        .lock_toggle (lock_toggle)
    );

    hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
        .clk      (clk),
        .rst_n    (rst_n),
        .hpie     (ctrl_word[B_HPIE]),
        .evt_en   (ctrl_word & EVT_MASK),
        .evt_stat (stat_word & EVT_MASK),
        .msix_en  (msix_en),
        .msi_en   (msi_en),
        .irq_vec  (irq_vec),
        .msg_req  (msg_req),
        .msg_msix (msg_msix),
        .msg_vec  (msg_vec),
        .intx     (intx)
    );

    assign rd_data = rd_sel ? stat_word : ctrl_word;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!hp_busy && !msg_req && !intx));
endmodule

// File: tb/hp_slot_ctrl_tb_top.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        ins_req = 1'b0, rem_req = 1'b0, cold_flag = 1'b0, btn_press = 1'b0;
    logic        msix_en = 1'b0, msi_en = 1'b0;
    logic [4:0]  irq_vec = 5'd0;
    logic        hp_busy, msg_req, msg_msix, intx;
    logic [4:0]  msg_vec;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    typedef struct {
        int          due;
        int          what;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    hp_slot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ins_req(ins_req),
        .rem_req(rem_req), .cold_flag(cold_flag), .btn_press(btn_press),
        .msix_en(msix_en), .msi_en(msi_en), .irq_vec(irq_vec), .hp_busy(hp_busy),
        .msg_req(msg_req), .msg_msix(msg_msix), .msg_vec(msg_vec), .intx(intx)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    // what: 0 ctrl, 1 status, 2 intx, 3 msg_req, 4 busy, 5 msg_vec, 6 msg_msix
    task automatic expect_at(int dly, int what, logic [15:0] v, string r);
        item_t it;
        it.due = cyc + dly; it.what = what; it.exp = v; it.req = r;
        sb.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due == cyc) begin
                    item_t it;
                    logic [15:0] act;
                    it = sb[i];
                    sb.delete(i);
                    act = 16'h0;
                    case (it.what)
                        0: begin rd_sel = 1'b0; #0.1; act = rd_data; end
                        1: begin rd_sel = 1'b1; #0.1; act = rd_data; end
                        2: act = {15'h0, intx};
                        3: act = {15'h0, msg_req};
                        4: act = {15'h0, hp_busy};
                        5: act = {11'h0, msg_vec};
                        default: act = {15'h0, msg_msix};
                    endcase
                    n_cmp++;
                    if (act !== it.exp) begin
                        n_bad++;
                        $display("FAIL %s item %0d at cycle %0d: actual=%h expected=%h",
                                 it.req, it.what, cyc, act, it.exp);
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(bit sel, logic [1:0] be, logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
        tick();
        wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0;
    endtask

    task automatic ev(bit i, bit r, bit c, bit b);
        ins_req = i; rem_req = r; cold_flag = c; btn_press = b;
        tick();
        ins_req = 0; rem_req = 0; cold_flag = 0; btn_press = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(0, 0, 16'h03C0, "R1"); expect_at(0, 1, 16'h0000, "R1");
        expect_at(0, 2, 16'h0, "R1"); expect_at(0, 3, 16'h0, "R1");
        expect_at(0, 4, 16'h0, "R1");
        tick();
        // R2/R3 high byte write is a command
        wr(1'b0, 2'b10, 16'h0000);
        expect_at(0, 0, 16'h00C0, "R2"); expect_at(0, 1, 16'h0010, "R3");
        tick();
        // R4 clear command-done
        wr(1'b1, 2'b01, 16'h0010);
        expect_at(0, 1, 16'h0000, "R4");
        tick();
        // R3 no byte enabled: no command
        wr(1'b0, 2'b00, 16'hFFFF);
        expect_at(0, 0, 16'h00C0, "R3"); expect_at(0, 1, 16'h0000, "R3");
        tick();
        // R2 reserved low bits
        wr(1'b0, 2'b01, 16'h0006);
        expect_at(0, 0, 16'h0000, "R2"); expect_at(0, 1, 16'h0010, "R3");
        tick();
        // R2 reserved high bits
        wr(1'b0, 2'b10, 16'hF6FF);
        expect_at(0, 0, 16'h0200, "R2");
        tick();
        // R5 interlock engage, control bit reads 0
        wr(1'b0, 2'b10, 16'h0800);
        expect_at(0, 0, 16'h0000, "R5"); expect_at(0, 1, 16'h0090, "R5");
        tick();
        // R8 hot insertion refused
        ev(1, 0, 0, 0);
        expect_at(0, 4, 16'h1, "R8"); expect_at(0, 1, 16'h0090, "R8");
        expect_at(1, 4, 16'h0, "R8");
        tick();
        // R8 removal refused
        ev(0, 1, 0, 0);
        expect_at(0, 4, 16'h1, "R8"); expect_at(0, 1, 16'h0090, "R8");
        tick();
        // R7 cold insertion accepted while locked
        ev(1, 0, 1, 0);
        expect_at(0, 1, 16'h00D0, "R7"); expect_at(0, 4, 16'h0, "R7");
        tick();
        // R5 release
        wr(1'b0, 2'b10, 16'h0800);
        expect_at(0, 1, 16'h0050, "R5");
        tick();
        // R4 bits 6/7 unaffected
        wr(1'b1, 2'b01, 16'h00FF);
        expect_at(0, 1, 16'h0040, "R4");
        tick();
        // R6 removal
        ev(0, 1, 0, 0);
        expect_at(0, 1, 16'h0008, "R6");
        tick();
        wr(1'b1, 2'b01, 16'h0008);
        expect_at(0, 1, 16'h0000, "R4");
        tick();
        // R6 tie: insertion wins
        ev(1, 1, 0, 0);
        expect_at(0, 1, 16'h0048, "R6");
        tick();
        // R9 button
        ev(0, 0, 0, 1);
        expect_at(0, 1, 16'h0049, "R9");
        tick();
        // R4 high byte only clears nothing
        wr(1'b1, 2'b10, 16'hFFFF);
        expect_at(0, 1, 16'h0049, "R4");
        tick();
        wr(1'b1, 2'b01, 16'h0009);
        expect_at(0, 1, 16'h0040, "R4");
        tick();
        // R4 clear and new press in the same cycle
        btn_press = 1'b1;
        wr(1'b1, 2'b01, 16'h0001);
        btn_press = 1'b0;
        expect_at(0, 1, 16'h0041, "R4");
        tick();
        wr(1'b1, 2'b01, 16'h0001);
        expect_at(0, 1, 16'h0040, "R4");
        tick();
        // R10 enable hot-plug irq and presence change
        wr(1'b0, 2'b01, 16'h0028);
        expect_at(0, 0, 16'h0028, "R2"); expect_at(0, 1, 16'h0050, "R10");
        expect_at(1, 2, 16'h0, "R10");
        tick();
        ev(0, 1, 0, 0);
        expect_at(0, 1, 16'h0018, "R10"); expect_at(0, 2, 16'h0, "R10");
        expect_at(1, 2, 16'h1, "R10"); expect_at(1, 3, 16'h0, "R10");
        tick();
        wr(1'b1, 2'b01, 16'h0008);
        expect_at(0, 1, 16'h0010, "R10"); expect_at(0, 2, 16'h1, "R10");
        expect_at(1, 2, 16'h0, "R10");
        tick();
        // R11 MSI-X message
        msix_en = 1'b1; irq_vec = 5'd19;
        ev(1, 0, 0, 0);
        expect_at(0, 1, 16'h0058, "R11"); expect_at(0, 3, 16'h0, "R11");
        expect_at(1, 3, 16'h1, "R11"); expect_at(1, 6, 16'h1, "R11");
        expect_at(1, 5, 16'd19, "R11"); expect_at(1, 2, 16'h0, "R11");
        tick();
        expect_at(0, 3, 16'h1, "R11"); expect_at(1, 3, 16'h0, "R11");
        tick();
        // R11 already-set event: no message
        ev(1, 0, 0, 0);
        expect_at(0, 1, 16'h0058, "R11"); expect_at(1, 3, 16'h0, "R11");
        tick();
        wr(1'b1, 2'b01, 16'h0008);
        expect_at(0, 1, 16'h0050, "R11"); expect_at(1, 3, 16'h0, "R11");
        tick();
        // R11 MSI message
        msix_en = 1'b0; msi_en = 1'b1; irq_vec = 5'd7;
        ev(0, 1, 0, 0);
        expect_at(0, 1, 16'h0018, "R11"); expect_at(1, 3, 16'h1, "R11");
        expect_at(1, 6, 16'h0, "R11"); expect_at(1, 5, 16'd7, "R11");
        tick();
        tick();
        // R4 clear and removal in the same cycle while pending
        rem_req = 1'b1;
        wr(1'b1, 2'b01, 16'h0008);
        rem_req = 1'b0;
        expect_at(0, 1, 16'h0018, "R4"); expect_at(1, 3, 16'h0, "R11");
        tick();
        tick();
        tick();
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule